// File: doc/BRIEF.md
# Speed-Selectable Sample Period Timer

This block generates the sample-period timing for an audio output path. It runs on the system clock. A single input selects normal speed, which gives 384 system clocks per sample period, or double speed, which gives 192. The left/right frame clock arrives asynchronously. The block passes it through a synchroniser and detects its rising edge.

After an active-low reset, the block waits for the first rising edge of the frame clock and aligns its period counter to that edge. From then on the counter runs free, and later frame-clock edges or phase drift have no effect on the count sequence. On every period the block produces three strobes: a sample strobe at the start of the period, a left-channel strobe at the start of the period, and a right-channel strobe at the midpoint. It also drives a channel phase level. A mute flag stays asserted through reset, through the wait for alignment, and for a configurable number of full periods after alignment.

A change of the speed input while the counter is running is taken only at a period boundary, so a period is never cut short or stretched by a mid-period change.

Top module: `frame_timer`

## Requirements
- R1: With the speed input low (0), consecutive sample strobes are exactly 384 system clock cycles apart.
- R2: With the speed input high (1), consecutive sample strobes are exactly 192 system clock cycles apart.
- R3: While the reset input is low, the sample strobe, both channel strobes and the channel phase are low, and mute is high.
- R4: If the frame clock is sampled high at a clock edge and was sampled low at the previous edge, the first sample strobe is high in the cycle that follows the second clock edge after that one. This is a latency of three edges, counting the sampling edge.
- R5: The frame clock is treated as high during reset. A frame clock that is already high at reset release does not align the counter, so no strobe appears until the frame clock has been sampled low and then high.
- R6: Once aligned, the counter ignores further frame-clock edges, their phase and their absence. Every window of N consecutive periods' worth of cycles contains exactly N sample strobes.
- R7: Mute stays high until MUTE_PERIODS full periods have completed after alignment, then goes low and stays low until the next reset.
- R8: The channel phase is high for counts below half the active period (counts 0 to 191 at normal speed, 0 to 95 at double speed) and low for the rest of the period. It is low before alignment.
- R9: The left strobe coincides with the sample strobe at count 0. The right strobe is a one-cycle pulse at the count equal to half the active period. The two are never high together.
- R10: A change of the speed input takes effect at the next count-zero boundary. The period in progress keeps its length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset, forces re-alignment |
| speed_dbl | input | 1 | Speed select: 0 gives the normal period, 1 gives the double-speed period |
| frame_clk | input | 1 | Asynchronous left/right frame clock |
| sample_stb | output | 1 | One-cycle pulse at count zero of each period |
| left_stb | output | 1 | Left channel strobe at count zero |
| right_stb | output | 1 | Right channel strobe at the half-period count |
| chan_phase | output | 1 | High during the first half of the period |
| mute | output | 1 | High until alignment plus the settling periods have passed |

## Verification
The bench keeps the default periods of 384 and 192 and the two-stage synchroniser, so both real period lengths and their half-period points are checked. MUTE_PERIODS is lowered to 3. This lets the mute release, a speed change in both directions at a boundary, and a second reset with the frame clock held high all fit in a short run. Frame-clock toggling at random phase after alignment shows that the counter does not move once locked.

// File: rtl/ft_pkg.sv
package ft_pkg;

    typedef enum logic {
        ALIGN_WAIT = 1'b0,
        ALIGN_RUN  = 1'b1
    } align_t;

endpackage

// File: rtl/ft_edge_sync.sv
module ft_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);

    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d       = sync_q;
        sync_d.chain = {sync_q.chain[STAGES-2:0], async_in};
        sync_d.prev  = sync_q.chain[STAGES-1];
    end

    // Reset to ones: an input already high at release is not an edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
        end else begin
            sync_q <= sync_d;
        end
    end

    assign rise = sync_q.chain[STAGES-1] & ~sync_q.prev;

    assert_rise_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);

endmodule

// File: rtl/ft_period_counter.sv
module ft_period_counter
    import ft_pkg::*;
#(
    parameter int NORMAL_PERIOD = 384,
    parameter int DOUBLE_PERIOD = 192,
    localparam int CW = $clog2(NORMAL_PERIOD)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rise,
    input  logic          speed_dbl,
    output logic          running,
    output logic          dbl,
    output logic [CW-1:0] cnt,
    output logic          wrap
);

    localparam logic [CW-1:0] LAST_NORMAL = CW'(NORMAL_PERIOD - 1);
    localparam logic [CW-1:0] LAST_DOUBLE = CW'(DOUBLE_PERIOD - 1);

    typedef struct packed {
        align_t        st;
        logic          dbl;
        logic [CW-1:0] cnt;
    } ctr_t;

    ctr_t ctr_d, ctr_q;
    logic [CW-1:0] last;

    always_comb begin
        ctr_d = ctr_q;
        last  = ctr_q.dbl ? LAST_DOUBLE : LAST_NORMAL;
        wrap  = (ctr_q.st == ALIGN_RUN) && (ctr_q.cnt == last);
        if (ctr_q.st == ALIGN_WAIT) begin
            if (rise) begin
                ctr_d.st  = ALIGN_RUN;
                ctr_d.cnt = '0;
                ctr_d.dbl = speed_dbl;
            end
        end else if (wrap) begin
            ctr_d.cnt = '0;
            ctr_d.dbl = speed_dbl;
        end else begin
            ctr_d.cnt = ctr_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctr_q <= '{st: ALIGN_WAIT, dbl: 1'b0, cnt: '0};
        end else begin
            ctr_q <= ctr_d;
        end
    end

    assign running = (ctr_q.st == ALIGN_RUN);
    assign dbl     = ctr_q.dbl;
    assign cnt     = ctr_q.cnt;

    assert_cnt_in_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> (cnt <= LAST_NORMAL));

    assert_double_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (running && dbl) |-> (cnt <= LAST_DOUBLE));

    assert_wait_at_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> (cnt == '0));

    assert_stay_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        running |=> running);

    assert_speed_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (running && $past(running) && cnt != '0) |-> $stable(dbl));

endmodule

// File: rtl/ft_mute_ctrl.sv
module ft_mute_ctrl #(
    parameter int MUTE_PERIODS = 8,
    localparam int PW = $clog2(MUTE_PERIODS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic running,
    input  logic wrap,
    output logic mute
);

    localparam logic [PW-1:0] DONE = PW'(MUTE_PERIODS);

    typedef struct packed {
        logic [PW-1:0] periods;
    } mute_t;

    mute_t mute_d, mute_q;

    always_comb begin
        mute_d = mute_q;
        if (wrap && mute_q.periods != DONE) begin
            mute_d.periods = mute_q.periods + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mute_q <= '{periods: '0};
        end else begin
            mute_q <= mute_d;
        end
    end

    assign mute = !running || (mute_q.periods != DONE);

    assert_mute_before_lock_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> mute);

    assert_mute_stays_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!mute && running) |=> !mute);

endmodule

// File: rtl/frame_timer.sv
module frame_timer #(
    parameter int NORMAL_PERIOD = 384,
    parameter int DOUBLE_PERIOD = 192,
    parameter int MUTE_PERIODS  = 8,
    parameter int SYNC_STAGES   = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic speed_dbl,
    input  logic frame_clk,
    output logic sample_stb,
    output logic left_stb,
    output logic right_stb,
    output logic chan_phase,
    output logic mute
);

    localparam int CW = $clog2(NORMAL_PERIOD);
    localparam logic [CW-1:0] HALF_NORMAL = CW'(NORMAL_PERIOD / 2);
    localparam logic [CW-1:0] HALF_DOUBLE = CW'(DOUBLE_PERIOD / 2);

    logic          rise;
    logic          running;
    logic          dbl;
    logic          wrap;
    logic [CW-1:0] cnt;
    logic [CW-1:0] half;

    ft_edge_sync #(
        .STAGES(SYNC_STAGES)
    ) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_in(frame_clk),
        .rise    (rise)
    );

    ft_period_counter #(
        .NORMAL_PERIOD(NORMAL_PERIOD),
        .DOUBLE_PERIOD(DOUBLE_PERIOD)
    ) i_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .rise     (rise),
        .speed_dbl(speed_dbl),
        .running  (running),
        .dbl      (dbl),
        .cnt      (cnt),
        .wrap     (wrap)
    );

    ft_mute_ctrl #(
        .MUTE_PERIODS(MUTE_PERIODS)
    ) i_mute (
        .clk    (clk),
        .rst_n  (rst_n),
        .running(running),
        .wrap   (wrap),
        .mute   (mute)
    );

    always_comb begin
        half       = dbl ? HALF_DOUBLE : HALF_NORMAL;
        sample_stb = running && (cnt == '0);
        left_stb   = running && (cnt == '0);
        right_stb  = running && (cnt == half);
        chan_phase = running && (cnt < half);
    end

    assert_stb_one_cycle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |=> !sample_stb);

    assert_lr_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({left_stb, right_stb}));

    assert_phase_falls_at_right_R8: assert property (@(posedge clk) disable iff (!rst_n)
        right_stb |-> !chan_phase);

    assert_phase_high_at_stb_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |-> chan_phase);

endmodule

// File: tb/test_frame_timer.sv
`timescale 1ns/1ps
module test_frame_timer;

    localparam int NP = 384;
    localparam int DP = 192;
    localparam int MP = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic speed_dbl = 1'b0;
    logic frame_clk = 1'b0;
    logic sample_stb, left_stb, right_stb, chan_phase, mute;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    frame_timer #(
        .NORMAL_PERIOD(NP),
        .DOUBLE_PERIOD(DP),
        .MUTE_PERIODS (MP),
        .SYNC_STAGES  (2)
    ) i_frame_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .speed_dbl (speed_dbl),
        .frame_clk (frame_clk),
        .sample_stb(sample_stb),
        .left_stb  (left_stb),
        .right_stb (right_stb),
        .chan_phase(chan_phase),
        .mute      (mute)
    );

    function automatic int period_of(input bit d);
        return d ? DP : NP;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Reference model built from the requirements, advanced at each rising edge.
    bit m_run = 0;
    bit m_dbl = 0;
    int m_cnt = 0;
    int m_per = 0;
    int pend  = 0;
    bit last_s = 1;
    int cyc = 0;

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_run = 0; m_dbl = 0; m_cnt = 0; m_per = 0; pend = 0; last_s = 1;
        end else begin
            if (m_run) begin
                if (m_cnt == period_of(m_dbl) - 1) begin
                    m_cnt = 0;
                    m_dbl = speed_dbl;
                    if (m_per < MP) m_per++;
                end else begin
                    m_cnt++;
                end
            end else if (pend > 0) begin
                pend--;
                if (pend == 0) begin
                    m_run = 1; m_cnt = 0; m_dbl = speed_dbl; m_per = 0;
                end
            end
            if (!m_run && pend == 0 && !last_s && frame_clk) pend = 2;
            last_s = frame_clk;
        end
    end

    int stb_n = 0;
    int last_stb = 0;
    int last_iv = 0;

    always @(negedge clk) begin
        if (!rst_n) begin
            chk(sample_stb == 0, "R3 sample_stb", sample_stb, 0);
            chk(left_stb == 0 && right_stb == 0, "R3 channel strobes", {left_stb, right_stb}, 0);
            chk(chan_phase == 0, "R3 chan_phase", chan_phase, 0);
            chk(mute == 1, "R3 mute", mute, 1);
        end else begin
            automatic int p = period_of(m_dbl);
            automatic bit e_stb = m_run && m_cnt == 0;
            chk(sample_stb == e_stb, !m_run ? "R4 sample_stb" : (m_dbl ? "R2 sample_stb" : "R1 sample_stb"),
                sample_stb, e_stb);
            chk(left_stb == e_stb, "R9 left_stb", left_stb, e_stb);
            chk(right_stb == (m_run && m_cnt == p / 2), "R9 right_stb", right_stb, m_run && m_cnt == p / 2);
            chk(chan_phase == (m_run && m_cnt < p / 2), "R8 chan_phase", chan_phase, m_run && m_cnt < p / 2);
            chk(mute == (!m_run || m_per < MP), "R7 mute", mute, !m_run || m_per < MP);
        end
        if (sample_stb) begin
            last_iv = cyc - last_stb;
            last_stb = cyc;
            stb_n++;
        end
    end

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic wait_stb();
        do step(); while (!sample_stb);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin
        int n0;
        void'($urandom(32'd5877));
        repeat (4) step();
        chk(mute == 1 && sample_stb == 0, "R3 reset state", {mute, sample_stb}, 2);
        rst_n = 1'b1;
        repeat (3 + $urandom_range(0, 17)) step();

        // R4: alignment latency after the first sampled rise
        n0 = stb_n;
        frame_clk = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        chk(sample_stb == 1, "R4 first strobe latency", sample_stb, 1);
        chk(stb_n == n0 + 1, "R4 no early strobe", stb_n, n0 + 1);

        // R6: frame clock wanders after lock
        repeat (5) step();
        n0 = stb_n;
        for (int i = 0; i < 6 * NP; i++) begin
            if ($urandom_range(0, 99) < 3) frame_clk = ~frame_clk;
            step();
        end
        chk(stb_n == n0 + 6, "R6 strobes per window", stb_n - n0, 6);
        chk(last_iv == NP, "R1 normal period", last_iv, NP);
        chk(mute == 0, "R7 mute released", mute, 0);

        // R10: switch to double speed mid-period
        wait_stb();
        repeat ($urandom_range(10, 300)) step();
        speed_dbl = 1'b1;
        wait_stb();
        chk(last_iv == NP, "R10 period in progress kept", last_iv, NP);
        wait_stb();
        chk(last_iv == DP, "R2 double period", last_iv, DP);
        repeat ($urandom_range(10, 150)) step();
        speed_dbl = 1'b0;
        wait_stb();
        chk(last_iv == DP, "R10 double period kept", last_iv, DP);
        wait_stb();
        chk(last_iv == NP, "R1 back to normal", last_iv, NP);

        // R5: frame clock already high at reset release
        frame_clk = 1'b1;
        step();
        rst_n = 1'b0;
        repeat (3) step();
        rst_n = 1'b1;
        n0 = stb_n;
        repeat (50) step();
        chk(stb_n == n0, "R5 no strobe while input held high", stb_n - n0, 0);
        chk(mute == 1, "R5 still muted", mute, 1);
        frame_clk = 1'b0;
        step();
        frame_clk = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        chk(sample_stb == 1, "R5 lock after low then high", sample_stb, 1);

        // Random mix of speed changes, frame clock noise and resets
        for (int it = 0; it < 30; it++) begin
            automatic int len = $urandom_range(1, 500);
            if ($urandom_range(0, 9) == 0) begin
                rst_n = 1'b0;
                repeat (2) step();
                rst_n = 1'b1;
            end
            speed_dbl = $urandom_range(0, 1);
            for (int k = 0; k < len; k++) begin
                if ($urandom_range(0, 99) < 5) frame_clk = ~frame_clk;
                step();
            end
        end

        finish_run();
    end

endmodule